// File: doc/BRIEF.md
# Auxiliary Packet Slot Scheduler

This block walks a software-programmed list of auxiliary packet types once per video frame. It asks a downstream packet sender to transmit each listed packet in turn. The list holds eight 4-bit type fields, split over two slot words of four fields each. A frame-start pulse rewinds the walk to the first field. A field holding the end code finishes the walk early. Any field holding a code the sender cannot build is passed over without a request.

Each request is a level held with its type code until the sender acknowledges it. The scheduler then moves to the next field. New requests are raised only while the blanking input is high. Outside blanking the walk waits at its current field. A busy flag shows that a walk is still in progress for the current frame. Only the slot fields are wired into the block; the upper halves of the 32-bit control words that hold them carry no slots.

Top module: `pkt_slot_sched`

## Requirements
- R1: After a synchronous reset, busy and pkt_req are low, pkt_slot is 0 and pkt_type is 0, and they stay so until frame_start.
- R2: Field n for n = 0..3 is slot_list_lo[4n+3:4n]. Field n for n = 4..7 is slot_list_hi[4(n-4)+3:4(n-4)].
- R3: Fields are served strictly in ascending index order, with one request per sendable field. The index advances on the clock edge that sees pkt_ack with pkt_req high.
- R4: A field holding code 15 ends the walk. busy falls on the next edge, no request is raised for it, and no later field is read.
- R5: Reserved codes 4 and 6 to 14 are passed over without a request, one field per clock cycle.
- R6: Codes 0, 1, 2, 3 and 5 are sendable. A request carries exactly the field's code on pkt_type.
- R7: When no field holds code 15, the walk ends once field 7 is finished, whether acknowledged or passed over. busy falls and pkt_slot stays at 7.
- R8: frame_start restarts the walk at field 0 from any state. A pending request is dropped on that edge.
- R9: pkt_req stays high with pkt_type stable until acknowledged. pkt_ack is ignored while pkt_req is low.
- R10: A request is raised only on an edge where in_blank is high. Outside blanking the walk holds at its field with busy high.
- R11: busy is high from the edge after frame_start until the walk ends, and pkt_req is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_list_lo | input | 16 | Type fields 0 to 3 |
| slot_list_hi | input | 16 | Type fields 4 to 7 |
| frame_start | input | 1 | One-cycle pulse that starts a new walk |
| in_blank | input | 1 | High while requests may be raised |
| pkt_ack | input | 1 | Sender accepts the current request |
| pkt_req | output | 1 | Request to send packet of type pkt_type |
| pkt_type | output | 4 | Type code of the current or last request |
| pkt_slot | output | 3 | Index of the field being served |
| busy | output | 1 | Walk in progress for this frame |

## Verification
The bench builds the block with its defaults: 4-bit codes, four fields per word and eight fields in all. With these values, a walk that crosses from the low word into the high word, a list with no end code, and a list ending at field 0 each complete within a few dozen cycles. Acknowledge latency, blanking gaps and a frame restart during a pending request are varied against a behavioural model. The bench also compares the sequence of accepted packet types with the list expected for each pattern.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    CLS_SEND = 2'd0,
    CLS_SKIP = 2'd1,
    CLS_END  = 2'd2
  } code_class_e;
endpackage

// File: rtl/pss_slot_select.sv
module pss_slot_select #(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS*CODE_W-1:0] list_flat,
  input  logic [IDX_W-1:0]            idx,
  output logic [CODE_W-1:0]           code
);
  logic [CODE_W-1:0] field [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_field
    assign field[g] = list_flat[g*CODE_W +: CODE_W];
  end

  assign code = field[idx];
endmodule

// File: rtl/pss_code_class.sv
module pss_code_class import pss_pkg::*; #(
  parameter int unsigned         CODE_W    = 4,
  parameter logic [CODE_W-1:0]   END_CODE  = '1,
  parameter logic [(1<<CODE_W)-1:0] SEND_MASK = 16'h002F
) (
  input  logic [CODE_W-1:0] code,
  output code_class_e       cls
);
  always_comb begin
    if (code == END_CODE)     cls = CLS_END;
    else if (SEND_MASK[code]) cls = CLS_SEND;
    else                      cls = CLS_SKIP;
  end
endmodule

// File: rtl/pkt_slot_sched.sv
module pkt_slot_sched import pss_pkg::*; #(
  parameter int unsigned            CODE_W        = 4,
  parameter int unsigned            SLOTS_PER_REG = 4,
  parameter logic [CODE_W-1:0]      END_CODE      = '1,
  parameter logic [(1<<CODE_W)-1:0] SEND_MASK     = 16'h002F,
  localparam int unsigned REG_W     = SLOTS_PER_REG * CODE_W,
  localparam int unsigned NUM_SLOTS = 2 * SLOTS_PER_REG,
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  slot_list_lo,
  input  logic [REG_W-1:0]  slot_list_hi,
  input  logic              frame_start,
  input  logic              in_blank,
  input  logic              pkt_ack,
  output logic              pkt_req,
  output logic [CODE_W-1:0] pkt_type,
  output logic [IDX_W-1:0]  pkt_slot,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, req_q;
  logic [CODE_W-1:0] type_q;
  logic [CODE_W-1:0] cur_code;
  code_class_e       cur_cls;
  logic              at_last;

  // Low word supplies fields 0..SLOTS_PER_REG-1, high word the rest.
  pss_slot_select #(
    .CODE_W   (CODE_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_sel (
    .list_flat({slot_list_hi, slot_list_lo}),
    .idx      (idx_q),
    .code     (cur_code)
  );

  pss_code_class #(
    .CODE_W   (CODE_W),
    .END_CODE (END_CODE),
    .SEND_MASK(SEND_MASK)
  ) u_cls (
    .code(cur_code),
    .cls (cur_cls)
  );

  assign at_last = (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      type_q <= '0;
    end else if (frame_start) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
      req_q  <= 1'b0;
    end else if (busy_q) begin
      if (req_q) begin
        if (pkt_ack) begin
          req_q <= 1'b0;
          if (at_last) busy_q <= 1'b0;
          else         idx_q  <= idx_q + 1'b1;
        end
      end else begin
        unique case (cur_cls)
          CLS_END: busy_q <= 1'b0;
          CLS_SKIP: begin
            if (at_last) busy_q <= 1'b0;
            else         idx_q  <= idx_q + 1'b1;
          end
          CLS_SEND: begin
            if (in_blank) begin
              req_q  <= 1'b1;
              type_q <= cur_code;
            end
          end
          default: busy_q <= 1'b0;
        endcase
      end
    end
  end

  assign pkt_req  = req_q;
  assign pkt_type = type_q;
  assign pkt_slot = idx_q;
  assign busy     = busy_q;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int unsigned            CODE_W    = 4,
  parameter int unsigned            IDX_W     = 3,
  parameter logic [(1<<CODE_W)-1:0] SEND_MASK = 16'h002F
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_start,
  input logic              in_blank,
  input logic              pkt_ack,
  input logic              pkt_req,
  input logic [CODE_W-1:0] pkt_type,
  input logic [IDX_W-1:0]  pkt_slot,
  input logic              busy
);
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    pkt_req && !pkt_ack && !frame_start |=> pkt_req && $stable(pkt_type));

  a_r3_release_on_ack: assert property (@(posedge clk) disable iff (rst)
    pkt_req && pkt_ack && !frame_start |=> !pkt_req);

  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> busy && !pkt_req && (pkt_slot == '0));

  a_r10_blank_only: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_req) |-> $past(in_blank));

  a_r6_sendable_code: assert property (@(posedge clk) disable iff (rst)
    pkt_req |-> SEND_MASK[pkt_type]);

  a_r11_req_within_busy: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pkt_req);

  a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
    busy && !frame_start |=>
      (pkt_slot == $past(pkt_slot)) || (pkt_slot == $past(pkt_slot) + 1'b1));
endmodule

bind pkt_slot_sched pss_checker #(
  .CODE_W   (CODE_W),
  .IDX_W    (IDX_W),
  .SEND_MASK(SEND_MASK)
) u_pss_checker (
  .clk        (clk),
  .rst        (rst),
  .frame_start(frame_start),
  .in_blank   (in_blank),
  .pkt_ack    (pkt_ack),
  .pkt_req    (pkt_req),
  .pkt_type   (pkt_type),
  .pkt_slot   (pkt_slot),
  .busy       (busy)
);

// File: tb/test_pkt_slot_sched.sv
`timescale 1ns/1ps
module test_pkt_slot_sched;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] slot_list_lo = '0;
  logic [15:0] slot_list_hi = '0;
  logic        frame_start = 1'b0;
  logic        in_blank = 1'b1;
  logic        pkt_ack = 1'b0;
  logic        pkt_req;
  logic [3:0]  pkt_type;
  logic [2:0]  pkt_slot;
  logic        busy;

  always #4 clk = ~clk;

  pkt_slot_sched i_pkt_slot_sched (
    .clk, .rst, .slot_list_lo, .slot_list_hi, .frame_start, .in_blank,
    .pkt_ack, .pkt_req, .pkt_type, .pkt_slot, .busy
  );

  int    vectors = 0, errors = 0;
  string tag = "R1";
  int    ack_mode = 0, ack_delay = 1, blank_mode = 0, wait_cnt = 0, cyc = 0;
  bit    fs_req = 0;
  int    got[$];
  int    ex[$];

  // Behavioural reference model
  bit m_busy = 0, m_req = 0;
  int m_slot = 0, m_type = 0;

  function automatic int code_at(int s);
    logic [15:0] w = (s < 4) ? slot_list_lo : slot_list_hi;
    return int'(w[4*(s%4) +: 4]);
  endfunction

  function automatic bit sendable(int c);
    return (c == 0) || (c == 1) || (c == 2) || (c == 3) || (c == 5);
  endfunction

  always @(posedge clk) begin
    int c;
    if (rst) begin
      m_busy = 0; m_req = 0; m_slot = 0; m_type = 0;
    end else if (frame_start) begin
      m_busy = 1; m_req = 0; m_slot = 0;
    end else if (m_busy) begin
      c = code_at(m_slot);
      if (m_req) begin
        if (pkt_ack) begin
          m_req = 0;
          if (m_slot == NS-1) m_busy = 0; else m_slot++;
        end
      end else if (c == 15) m_busy = 0;
      else if (!sendable(c)) begin
        if (m_slot == NS-1) m_busy = 0; else m_slot++;
      end else if (in_blank) begin
        m_req = 1; m_type = c;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      cyc++;
      vectors++;
      if (busy !== m_busy || pkt_req !== m_req ||
          int'(pkt_type) != m_type || int'(pkt_slot) != m_slot) begin
        errors++;
        $display("FAIL %s: busy/req/type/slot act=%0b/%0b/%0d/%0d exp=%0b/%0b/%0d/%0d",
                 tag, busy, pkt_req, pkt_type, pkt_slot, m_busy, m_req, m_type, m_slot);
      end
      in_blank = (blank_mode == 0) ? 1'b1 : ((cyc % 5) < 2);
      if (pkt_req) wait_cnt++; else wait_cnt = 0;
      case (ack_mode)
        0:       pkt_ack = pkt_req && (wait_cnt > ack_delay);
        1:       pkt_ack = 1'b1;
        default: pkt_ack = 1'b0;
      endcase
      frame_start = fs_req;
      fs_req = 0;
      if (pkt_req && pkt_ack && !frame_start && !rst) got.push_back(int'(pkt_type));
    end
  endtask

  task automatic new_frame();
    fs_req = 1;
    step(1);
    got.delete();
  endtask

  task automatic expect_list(string t);
    vectors++;
    if (got != ex) begin
      errors++;
      $display("FAIL %s: sent types act=%p exp=%p", t, got, ex);
    end
    got.delete();
  endtask

  initial begin
    // R1: reset state
    tag = "R1"; rst = 1; step(3); rst = 0; step(3);

    // R3 / R4: typical list 1,2,3 then end code
    tag = "R3"; slot_list_lo = 16'hF321; slot_list_hi = 16'h0000;
    new_frame(); step(30); ex = {1, 2, 3}; expect_list("R3/R4");

    // R2: field mapping across both words, end code in field 7
    tag = "R2"; slot_list_lo = 16'h0123; slot_list_hi = 16'hF005;
    new_frame(); step(40); ex = {3, 2, 1, 0, 5, 0, 0}; expect_list("R2");

    // R7: no end code, all eight fields sent; slower acknowledge
    tag = "R7"; ack_delay = 3; slot_list_lo = 16'h2105; slot_list_hi = 16'h5321;
    new_frame(); step(60); ex = {5, 0, 1, 2, 1, 2, 3, 5}; expect_list("R7");

    // R5 / R6: reserved codes passed over; fast acknowledge
    tag = "R5"; ack_delay = 0; slot_list_lo = 16'hE461; slot_list_hi = 16'h0F29;
    new_frame(); step(30); ex = {1, 2}; expect_list("R5/R6");

    // R10: requests only during blanking
    tag = "R10"; blank_mode = 1; ack_delay = 1;
    slot_list_lo = 16'hF321; slot_list_hi = 16'h0000;
    new_frame(); step(60); ex = {1, 2, 3}; expect_list("R10");
    blank_mode = 0;

    // R8: restart while a request is pending
    tag = "R8"; ack_delay = 2; slot_list_lo = 16'h2105; slot_list_hi = 16'h5321;
    new_frame(); step(6); new_frame(); step(60);
    ex = {5, 0, 1, 2, 1, 2, 3, 5}; expect_list("R8");

    // R9: acknowledge held high, also while idle
    tag = "R9"; ack_mode = 1; slot_list_lo = 16'hF321; slot_list_hi = 16'h0000;
    step(5); ex.delete(); expect_list("R9 idle");
    new_frame(); step(20); ex = {1, 2, 3}; expect_list("R9");

    // R4 / R11: end code in field 0, busy for one cycle only
    tag = "R11"; ack_mode = 0; slot_list_lo = 16'h000F; slot_list_hi = 16'h1111;
    new_frame(); step(10); ex.delete(); expect_list("R4/R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; errors++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule